// File: doc/BRIEF.md
# Snooped L1 Coherency State Controller

This block holds the coherency bookkeeping for a small direct-mapped L1 data cache and for the valid array of a companion instruction cache. Another agent on a shared coherent bus sends snoop commands. The block takes each one with an address, a global flag and a command type. It looks up the indexed line and moves its MESI state, or clears the instruction-side valid bit. Data storage is kept elsewhere. This block only decides the state and reports when a dirty line has to be written out.

A clean or flush snoop that finds a Modified line raises a write-back request that carries the line-aligned address. The line stays Modified until that request is acknowledged. The snoop port is then stalled, so only one snoop is ever in flight. The local side installs lines through a fill port. A lookup port reports the stored state of any address, so the core, and a test bench, can see the coherency view of a line.

Top module: `snoop_coherency_ctrl`

## Requirements
- R1: A snoop accepted with `snp_global` low changes no data-side state and no instruction valid bit, and raises no write-back.
- R2: A global clean snoop that hits a line in S (01) or E (10) leaves it in S (01) on the clock edge that accepts it.
- R3: A global clean snoop whose tag does not match, or whose line is I (00), leaves the stored state unchanged.
- R4: A global flush snoop (`snp_kind` 01) or kill snoop (`snp_kind` 10) that hits a line in S or E leaves it in I on the accepting edge.
- R5: A global clean (`snp_kind` 00) or flush snoop that hits an M (11) line raises `wb_req` from the next cycle with `wb_addr` equal to the snoop address with its offset bits cleared. `wb_req` and `wb_addr` hold until `wb_ack`. The line reads M until then. On the acknowledging edge it becomes S for clean or I for flush.
- R6: A global kill snoop on an M line makes it I at once and raises no write-back.
- R7: `snp_ready` is low for every cycle that `wb_req` is high.
- R8: Only the instruction-kill snoop (`snp_kind` 11) touches the instruction array. It clears the valid bit of a tag-matching line, valid or not. It does not change data-side state. Clean, flush and kill leave instruction lines untouched.
- R9: Instruction lines become valid only through the fill port with `fill_iside` high. No snoop ever sets a valid bit.
- R10: A hit needs both a tag match and a state other than I. `look_dstate` returns the stored state (I=00, S=01, E=10, M=11) when the tag matches, and 00 otherwise. `look_ivalid` is high only for a valid instruction line with a matching tag.
- R11: When an accepted snoop and a fill name the same index in one cycle, `fill_ready` is low and the snoop takes effect. The fill is taken when it is offered again.
- R12: Synchronous active-low reset makes every data line I and every instruction line invalid. It also drops `wb_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snp_valid | input | 1 | Snoop command offered |
| snp_ready | output | 1 | Snoop command can be taken |
| snp_addr | input | ADDR_W | Snooped byte address |
| snp_global | input | 1 | Coherency-required flag of the transaction |
| snp_kind | input | 2 | 00 clean, 01 flush, 10 kill, 11 instruction kill |
| fill_valid | input | 1 | Local fill offered |
| fill_ready | output | 1 | Local fill can be taken |
| fill_addr | input | ADDR_W | Address of the line to install |
| fill_iside | input | 1 | 1 installs an instruction line, 0 a data line |
| fill_state | input | 2 | MESI state for a data fill |
| wb_req | output | 1 | Modified line must be written back |
| wb_addr | output | ADDR_W | Line-aligned write-back address |
| wb_ack | input | 1 | Write-back accepted |
| look_addr | input | ADDR_W | Lookup address |
| look_dstate | output | 2 | Data-side state seen at the lookup address |
| look_ivalid | output | 1 | Instruction line valid at the lookup address |

## Verification
Directed cases put each MESI state under each of the four commands, with the flag both high and low. This separates the downgrade from the invalidations, and separates a missed snoop from a matching one on the same index. Snoops on Modified lines are acknowledged after varying delays. This shows whether the state change waits for the acknowledge and whether the port stays stalled meanwhile. A same-index snoop and fill in one cycle tests the priority. Seeded random traffic over two tags per index then mixes fills and snoops of both sides, so that cross-effects between the data state and the instruction valid bits show up against a bench model.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {ST_I = 2'b00, ST_S = 2'b01, ST_E = 2'b10, ST_M = 2'b11} mesi_e;
  typedef enum logic [1:0] {SN_CLEAN = 2'b00, SN_FLUSH = 2'b01, SN_KILL = 2'b10, SN_IKILL = 2'b11} snoop_e;

  // state a data line takes after a hitting data-side snoop
  function automatic mesi_e data_next(snoop_e k, mesi_e s);
    case (k)
      SN_CLEAN: return (s == ST_I) ? ST_I : ST_S;
      SN_FLUSH, SN_KILL: return ST_I;
      default: return s;
    endcase
  endfunction

  // dirty data leaves only for clean and flush
  function automatic logic wants_wb(snoop_e k, mesi_e s);
    return (s == ST_M) && (k == SN_CLEAN || k == SN_FLUSH);
  endfunction
endpackage

// File: rtl/coh_dside_array.sv
module coh_dside_array #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IDX_W-1:0]     ra_idx,
  output logic [TAG_W-1:0]     ra_tag,
  output coh_pkg::mesi_e       ra_st,
  input  logic [IDX_W-1:0]     rb_idx,
  output logic [TAG_W-1:0]     rb_tag,
  output coh_pkg::mesi_e       rb_st,
  input  logic                 fill_en,
  input  logic [IDX_W-1:0]     fill_idx,
  input  logic [TAG_W-1:0]     fill_tag,
  input  coh_pkg::mesi_e       fill_st,
  input  logic                 upd_en,
  input  logic [IDX_W-1:0]     upd_idx,
  input  coh_pkg::mesi_e       upd_st
);
  import coh_pkg::*;
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tags [LINES];
  mesi_e            sts  [LINES];

  assign ra_tag = tags[ra_idx];
  assign ra_st  = sts[ra_idx];
  assign rb_tag = tags[rb_idx];
  assign rb_st  = sts[rb_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        tags[i] <= '0;
        sts[i]  <= ST_I;
      end
    end else begin
      if (fill_en) begin
        tags[fill_idx] <= fill_tag;
        sts[fill_idx]  <= fill_st;
      end
      if (upd_en) sts[upd_idx] <= upd_st;
    end
  end
endmodule

// File: rtl/coh_iside_array.sv
module coh_iside_array #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] ra_idx,
  output logic [TAG_W-1:0] ra_tag,
  input  logic [IDX_W-1:0] rb_idx,
  output logic [TAG_W-1:0] rb_tag,
  output logic             rb_vld,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tags [LINES];
  logic [LINES-1:0] vld;

  assign ra_tag = tags[ra_idx];
  assign rb_tag = tags[rb_idx];
  assign rb_vld = vld[rb_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < LINES; i++) tags[i] <= '0;
    end else begin
      if (fill_en) begin
        tags[fill_idx] <= fill_tag;
        vld[fill_idx]  <= 1'b1;
      end
      if (clr_en) vld[clr_idx] <= 1'b0;
    end
  end
endmodule

// File: rtl/coh_wb_tracker.sv
module coh_wb_tracker #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [IDX_W-1:0]  start_idx,
  input  coh_pkg::mesi_e    start_final,
  input  logic              ack,
  output logic              pend,
  output logic              done,
  output logic [IDX_W-1:0]  pend_idx,
  output coh_pkg::mesi_e    pend_final,
  output logic [ADDR_W-1:0] pend_addr
);
  import coh_pkg::*;

  assign done = pend && ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      pend_idx   <= '0;
      pend_final <= ST_I;
      pend_addr  <= '0;
    end else if (start) begin
      pend       <= 1'b1;
      pend_idx   <= start_idx;
      pend_final <= start_final;
      pend_addr  <= start_addr;
    end else if (done) begin
      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/snoop_coherency_ctrl.sv
module snoop_coherency_ctrl #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  output logic              snp_ready,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              snp_global,
  input  logic [1:0]        snp_kind,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_iside,
  input  logic [1:0]        fill_state,
  output logic              wb_req,
  output logic [ADDR_W-1:0] wb_addr,
  input  logic              wb_ack,
  input  logic [ADDR_W-1:0] look_addr,
  output logic [1:0]        look_dstate,
  output logic              look_ivalid
);
  import coh_pkg::*;
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  // address fields
  logic [IDX_W-1:0] s_idx, f_idx, l_idx;
  logic [TAG_W-1:0] s_tag, f_tag, l_tag;
  assign s_idx = snp_addr[OFF_W +: IDX_W];
  assign s_tag = snp_addr[ADDR_W-1 -: TAG_W];
  assign f_idx = fill_addr[OFF_W +: IDX_W];
  assign f_tag = fill_addr[ADDR_W-1 -: TAG_W];
  assign l_idx = look_addr[OFF_W +: IDX_W];
  assign l_tag = look_addr[ADDR_W-1 -: TAG_W];

  snoop_e kind;
  assign kind = snoop_e'(snp_kind);

  // named internal events
  logic snp_fire, snp_act, d_hit, i_match, wb_start, upd_en, iclr_en, fill_fire;
  logic wb_pend, wb_done;
  logic [IDX_W-1:0] pend_idx, upd_idx;
  mesi_e pend_final, upd_st, d_st_s, d_st_l;
  logic [TAG_W-1:0] d_tag_s, d_tag_l, i_tag_s, i_tag_l;
  logic i_vld_l;

  assign snp_ready = !wb_pend;
  assign snp_fire  = snp_valid && snp_ready;
  assign snp_act   = snp_fire && snp_global;
  assign d_hit     = (d_tag_s == s_tag) && (d_st_s != ST_I);
  assign i_match   = (i_tag_s == s_tag);

  assign wb_start = snp_act && (kind != SN_IKILL) && d_hit && wants_wb(kind, d_st_s);
  assign iclr_en  = snp_act && (kind == SN_IKILL) && i_match;

  logic snp_dwr;
  assign snp_dwr = snp_act && (kind != SN_IKILL) && d_hit && !wb_start;
  assign upd_en  = snp_dwr || wb_done;
  assign upd_idx = wb_done ? pend_idx : s_idx;
  assign upd_st  = wb_done ? pend_final : data_next(kind, d_st_s);

  // snoop wins over a fill to the same index; pending write-back index is locked
  assign fill_ready = !((snp_fire && f_idx == s_idx) || (wb_pend && f_idx == pend_idx));
  assign fill_fire  = fill_valid && fill_ready;

  logic [ADDR_W-1:0] line_addr;
  assign line_addr = {snp_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  coh_dside_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_dside (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(s_idx), .ra_tag(d_tag_s), .ra_st(d_st_s),
    .rb_idx(l_idx), .rb_tag(d_tag_l), .rb_st(d_st_l),
    .fill_en(fill_fire && !fill_iside), .fill_idx(f_idx), .fill_tag(f_tag),
    .fill_st(mesi_e'(fill_state)),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_st(upd_st)
  );

  coh_iside_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_iside (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(s_idx), .ra_tag(i_tag_s),
    .rb_idx(l_idx), .rb_tag(i_tag_l), .rb_vld(i_vld_l),
    .fill_en(fill_fire && fill_iside), .fill_idx(f_idx), .fill_tag(f_tag),
    .clr_en(iclr_en), .clr_idx(s_idx)
  );

  coh_wb_tracker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_wb (
    .clk(clk), .rst_n(rst_n),
    .start(wb_start), .start_addr(line_addr), .start_idx(s_idx),
    .start_final(data_next(kind, d_st_s)), .ack(wb_ack),
    .pend(wb_pend), .done(wb_done), .pend_idx(pend_idx),
    .pend_final(pend_final), .pend_addr(wb_addr)
  );

  assign wb_req      = wb_pend;
  assign look_dstate = (d_tag_l == l_tag) ? d_st_l : ST_I;
  assign look_ivalid = i_vld_l && (i_tag_l == l_tag);
endmodule

// File: rtl/snoop_coherency_chk.sv
module snoop_coherency_chk #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              snp_valid,
  input logic              snp_ready,
  input logic              snp_global,
  input logic [1:0]        snp_kind,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              fill_valid,
  input logic              fill_ready,
  input logic [ADDR_W-1:0] fill_addr,
  input logic              wb_req,
  input logic              wb_ack,
  input logic [ADDR_W-1:0] wb_addr,
  input logic              upd_en,
  input logic              iclr_en,
  input logic              wb_start
);
  logic took;
  assign took = snp_valid && snp_ready;

  a_r1_nonglobal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    took && !snp_global |-> !upd_en && !iclr_en && !wb_start);
  a_r7_stall_during_wb: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> !snp_ready);
  a_r5_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_ack |=> wb_req && $stable(wb_addr));
  a_r5_wb_release: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && wb_ack |=> !wb_req);
  a_r5_wb_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> wb_addr[OFF_W-1:0] == '0);
  a_r6_kill_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    took && snp_kind == 2'b10 |=> !$rose(wb_req));
  a_r8_iside_only_ikill: assert property (@(posedge clk) disable iff (!rst_n)
    took && snp_kind != 2'b11 |-> !iclr_en);
  a_r11_fill_yields: assert property (@(posedge clk) disable iff (!rst_n)
    took && fill_valid && snp_addr[OFF_W +: IDX_W] == fill_addr[OFF_W +: IDX_W] |-> !fill_ready);
endmodule

bind snoop_coherency_ctrl snoop_coherency_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_ready(snp_ready),
  .snp_global(snp_global), .snp_kind(snp_kind), .snp_addr(snp_addr),
  .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_addr(fill_addr),
  .wb_req(wb_req), .wb_ack(wb_ack), .wb_addr(wb_addr),
  .upd_en(upd_en), .iclr_en(iclr_en), .wb_start(wb_start)
);

// File: tb/snoop_coherency_ctrl_bench.sv
module snoop_coherency_ctrl_bench;
  localparam int AW = 16, IW = 3, OW = 4, TW = AW - IW - OW, NL = 1 << IW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic snp_valid = 0, snp_global = 0, fill_valid = 0, fill_iside = 0, wb_ack = 0;
  logic [1:0] snp_kind = 0, fill_state = 0;
  logic [AW-1:0] snp_addr = 0, fill_addr = 0, look_addr = 0;
  logic snp_ready, fill_ready, wb_req, look_ivalid;
  logic [AW-1:0] wb_addr;
  logic [1:0] look_dstate;

  always #2.5 clk = ~clk;

  snoop_coherency_ctrl #(.ADDR_W(AW), .IDX_W(IW), .OFF_W(OW)) u_snoop_coherency_ctrl (
    .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_ready(snp_ready),
    .snp_addr(snp_addr), .snp_global(snp_global), .snp_kind(snp_kind),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_addr(fill_addr),
    .fill_iside(fill_iside), .fill_state(fill_state), .wb_req(wb_req),
    .wb_addr(wb_addr), .wb_ack(wb_ack), .look_addr(look_addr),
    .look_dstate(look_dstate), .look_ivalid(look_ivalid)
  );

  int tests = 0, fails = 0;
  logic [TW-1:0] m_dtag [NL];
  logic [1:0]    m_dst  [NL];
  logic [TW-1:0] m_itag [NL];
  logic          m_iv   [NL];

  function automatic logic [IW-1:0] idx_of(logic [AW-1:0] a); return a[OW +: IW]; endfunction
  function automatic logic [TW-1:0] tag_of(logic [AW-1:0] a); return a[AW-1 -: TW]; endfunction
  function automatic logic [AW-1:0] mk(int t, int i, int o);
    return AW'((t << (IW + OW)) | (i << OW) | o);
  endfunction
  // expected state after a hitting data snoop: clean -> S unless I, others -> I
  function automatic logic [1:0] exp_next(logic [1:0] k, logic [1:0] s);
    if (k == 2'b00) return (s == 2'b00) ? 2'b00 : 2'b01;
    return 2'b00;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_line(string req, logic [AW-1:0] a);
    logic [IW-1:0] i;
    i = idx_of(a);
    look_addr = a;
    #1;
    check({req, " dstate"}, 32'(look_dstate), (m_dtag[i] == tag_of(a)) ? 32'(m_dst[i]) : 0);
    check({req, " ivalid"}, 32'(look_ivalid), 32'(m_iv[i] && m_itag[i] == tag_of(a)));
  endtask

  task automatic do_fill(logic iside, logic [AW-1:0] a, logic [1:0] st);
    @(negedge clk);
    fill_valid = 1; fill_iside = iside; fill_addr = a; fill_state = st;
    @(negedge clk);
    fill_valid = 0;
    if (iside) begin m_itag[idx_of(a)] = tag_of(a); m_iv[idx_of(a)] = 1; end
    else begin m_dtag[idx_of(a)] = tag_of(a); m_dst[idx_of(a)] = st; end
  endtask

  task automatic do_snoop(string req, logic [1:0] k, logic [AW-1:0] a, logic g, int delay);
    logic [IW-1:0] i;
    logic hit, wb;
    i = idx_of(a);
    hit = (m_dtag[i] == tag_of(a)) && (m_dst[i] != 2'b00);
    wb = g && k != 2'b11 && hit && m_dst[i] == 2'b11 && k != 2'b10;
    @(negedge clk);
    snp_valid = 1; snp_kind = k; snp_addr = a; snp_global = g;
    @(negedge clk);
    snp_valid = 0;
    if (g && k == 2'b11 && m_itag[i] == tag_of(a)) m_iv[i] = 0;
    if (wb) begin
      check({req, " wb_req"}, 32'(wb_req), 1);
      check({req, " wb_addr"}, 32'(wb_addr), 32'({a[AW-1:OW], {OW{1'b0}}}));
      for (int d = 0; d < delay; d++) begin
        check({req, " R7 ready low"}, 32'(snp_ready), 0);
        check_line({req, " held M"}, a);
        @(negedge clk);
      end
      wb_ack = 1;
      @(negedge clk);
      wb_ack = 0;
      check({req, " wb dropped"}, 32'(wb_req), 0);
      m_dst[i] = exp_next(k, m_dst[i]);
    end else begin
      check({req, " no wb"}, 32'(wb_req), 0);
      if (g && k != 2'b11 && hit) m_dst[i] = exp_next(k, m_dst[i]);
    end
    check_line(req, a);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NL; i++) begin m_dtag[i] = 0; m_dst[i] = 0; m_itag[i] = 0; m_iv[i] = 0; end
    // warm the arrays with junk before reset to show reset clears them
    rst_n = 1;
    fill_valid = 1; fill_iside = 0; fill_state = 2'b11; fill_addr = mk(0, 2, 0);
    @(negedge clk); fill_iside = 1; @(negedge clk); fill_valid = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 reset state
    check("R12 ready", 32'(snp_ready), 1);
    check("R12 wb_req", 32'(wb_req), 0);
    for (int i = 0; i < NL; i++) check_line("R12", mk(0, i, 0));

    // R1 global low leaves M alone, no write-back
    do_fill(0, mk(1, 1, 0), 2'b11);
    do_snoop("R1 clean nonglobal", 2'b00, mk(1, 1, 4), 0, 0);
    do_snoop("R1 flush nonglobal", 2'b01, mk(1, 1, 4), 0, 0);
    // R2 clean on E and S
    do_fill(0, mk(1, 2, 0), 2'b10);
    do_snoop("R2 clean E", 2'b00, mk(1, 2, 0), 1, 0);
    do_snoop("R2 clean S", 2'b00, mk(1, 2, 0), 1, 0);
    // R3 clean miss (other tag) and on I
    do_fill(0, mk(2, 3, 0), 2'b10);
    do_snoop("R3 clean miss", 2'b00, mk(3, 3, 0), 1, 0);
    check_line("R3 other tag kept", mk(2, 3, 0));
    do_fill(0, mk(2, 4, 0), 2'b00);
    do_snoop("R3 clean on I", 2'b00, mk(2, 4, 0), 1, 0);
    // R4 flush E, kill S
    do_fill(0, mk(1, 5, 0), 2'b10);
    do_snoop("R4 flush E", 2'b01, mk(1, 5, 8), 1, 0);
    do_fill(0, mk(1, 6, 0), 2'b01);
    do_snoop("R4 kill S", 2'b10, mk(1, 6, 0), 1, 0);
    // R5 clean and flush on M with delayed ack
    do_snoop("R5 clean M", 2'b00, mk(1, 1, 12), 1, 3);
    do_fill(0, mk(4, 7, 0), 2'b11);
    do_snoop("R5 flush M", 2'b01, mk(4, 7, 5), 1, 0);
    // R6 kill on M discards
    do_fill(0, mk(5, 0, 0), 2'b11);
    do_snoop("R6 kill M", 2'b10, mk(5, 0, 0), 1, 0);
    // R8 instruction side only sees ikill; ikill spares data
    do_fill(1, mk(6, 2, 0), 2'b00);
    do_fill(0, mk(6, 2, 0), 2'b10);
    do_snoop("R8 clean on iline", 2'b00, mk(6, 2, 0), 1, 0);
    do_snoop("R8 kill on iline", 2'b10, mk(6, 2, 0), 1, 0);
    do_fill(0, mk(6, 2, 0), 2'b10);
    do_snoop("R8 ikill", 2'b11, mk(6, 2, 0), 1, 0);
    // R9 ikill on an invalid line leaves it invalid
    do_snoop("R9 ikill invalid", 2'b11, mk(6, 2, 0), 1, 0);
    // R10 lookup with a different tag reads I
    do_fill(0, mk(7, 3, 0), 2'b11);
    check_line("R10 tag mismatch", mk(8, 3, 0));
    check_line("R10 tag match", mk(7, 3, 0));
    // R11 same-index snoop and fill
    do_fill(0, mk(9, 4, 0), 2'b10);
    @(negedge clk);
    snp_valid = 1; snp_kind = 2'b10; snp_global = 1; snp_addr = mk(9, 4, 0);
    fill_valid = 1; fill_iside = 0; fill_addr = mk(10, 4, 0); fill_state = 2'b01;
    #1 check("R11 fill stalled", 32'(fill_ready), 0);
    @(negedge clk);
    snp_valid = 0;
    m_dst[4] = 2'b00;
    check_line("R11 snoop took effect", mk(9, 4, 0));
    check("R11 fill retry ready", 32'(fill_ready), 1);
    @(negedge clk);
    fill_valid = 0;
    m_dtag[4] = tag_of(mk(10, 4, 0)); m_dst[4] = 2'b01;
    check_line("R11 fill taken later", mk(10, 4, 0));

    // seeded random mix over two tags per index
    void'($urandom(32'd2024));
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      int op;
      a = mk($urandom_range(1), $urandom_range(NL - 1), $urandom_range(15));
      op = $urandom_range(9);
      if (op < 3) do_fill(op == 0, a, 2'($urandom_range(3)));
      else do_snoop("R2-R10 random", 2'($urandom_range(3)), a, $urandom_range(7) != 0,
                    $urandom_range(2));
      check_line("R10 random probe", mk($urandom_range(1), $urandom_range(NL - 1), 0));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule